// File: doc/BRIEF.md
# Modular Adder/Subtractor with Carry-Selected Reduction

This block returns (A + B) mod p or (A − B) mod p for unsigned operands that already lie in [0, p). It is one of the arithmetic units of a prime-field datapath. A surrounding sequencer places two residues and the modulus on the operand pins, picks the operation and pulses a start strobe. Two clock edges later a valid flag rises for one cycle, and the reduced result sits on the output.

The arithmetic uses two adders in a chain and makes no magnitude comparison. When adding, the first adder forms the full sum with its carry kept. The second adder adds the bitwise complement of p with a carry-in of one, which yields A + B − p. The carry-out of the second adder picks which of the two values is the answer. When subtracting, the first adder adds the complement of B with a carry-in of one. If that carry-out is low, the difference is negative, and the second adder's A − B + p is taken instead.

Top module: `modadd_unit`

## Requirements
- R1: While reset is asserted (rstN low), resultValid is 0. After reset releases, result reads 0 and resultValid stays 0 until an operation completes.
- R2: A start accepted while the unit is idle is sampled at clock edge E0. resultValid is high for exactly the one cycle that follows edge E0+1.
- R3: Between completions, result holds the last computed value.
- R4: With opSub = 0, the result is (opA + opB) mod modP. This holds when the sum equals modP (result 0) and when the sum overflows WIDTH bits.
- R5: With opSub = 1, the result is (opA − opB) mod modP. opA = opB gives 0, and opA = 0 with opB = modP − 1 gives 1.
- R6: A start asserted in the cycle right after an accepted start is ignored. It produces no second valid pulse, and the first result is not disturbed.
- R7: Operands, modulus and operation are captured at the accepting edge. Changes on those pins afterwards do not affect that operation's result.
- R8: Every valid result is strictly less than the modulus that was captured for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Begin an operation; accepted only while idle |
| opSub | input | 1 | 0 selects addition, 1 selects subtraction |
| opA | input | WIDTH | First operand, in [0, modP) |
| opB | input | WIDTH | Second operand, in [0, modP) |
| modP | input | WIDTH | Modulus |
| result | output | WIDTH | Reduced result |
| resultValid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench targets the reduction boundaries.

- **Sum equal to the modulus.** A design with the wrong carry polarity would leave p on the output instead of 0.
- **Sum just under the modulus.** A design that over-reduces would wrap this case.
- **Sum that overflows the operand width.** A design that drops the first adder's carry would return the unreduced low bits.
- **Equal operands and 0 − (p−1) under subtraction.** These catch a missing or inverted add-back of p.
- **Start held over two cycles and operand pins changed after acceptance.** These expose a controller that restarts itself or a datapath that reads live pins.

// File: rtl/modadd_pkg.sv
package modadd_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_CALC = 1'b1} ctrlState_t;

  typedef struct packed {
    logic loadOps;
    logic computeEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/modadd_cpa.sv
module modadd_cpa #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] yIn,
  input  logic             cIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             cOut
);
  localparam int EXT = WIDTH + 1;
  logic [EXT-1:0] wide;

  assign wide   = {1'b0, xIn} + {1'b0, yIn} + {{WIDTH{1'b0}}, cIn};
  assign sumOut = wide[WIDTH-1:0];
  assign cOut   = wide[WIDTH];
endmodule

// File: rtl/modadd_ctrl.sv
module modadd_ctrl
  import modadd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output ctrlStrobes_t strobes,
  output logic         validOut
);
  ctrlState_t state, stateNext;
  logic       validQ;

  always_comb begin
    stateNext         = state;
    strobes.loadOps   = 1'b0;
    strobes.computeEn = 1'b0;
    case (state)
      ST_IDLE: if (startIn) begin
        strobes.loadOps = 1'b1;
        stateNext       = ST_CALC;
      end
      ST_CALC: begin
        strobes.computeEn = 1'b1;
        stateNext         = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      validQ <= 1'b0;
    end else begin
      state  <= stateNext;
      validQ <= strobes.computeEn;
    end
  end

  assign validOut = validQ;
endmodule

// File: rtl/modadd_datapath.sv
module modadd_datapath
  import modadd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             opSub,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modP,
  output logic [WIDTH-1:0] result
);
  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] aReg, bReg, pReg, resReg;
  logic             subReg;

  logic [WIDTH-1:0] firstSum;
  logic             firstCarry;
  logic [EXT-1:0]   secondX, secondY, secondSum;
  logic             secondCarry;
  logic [WIDTH-1:0] picked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg   <= '0;
      bReg   <= '0;
      pReg   <= '0;
      subReg <= 1'b0;
    end else if (strobes.loadOps) begin
      aReg   <= opA;
      bReg   <= opB;
      pReg   <= modP;
      subReg <= opSub;
    end
  end

  // First adder: A + B, or A + ~B + 1 for subtraction.
  modadd_cpa #(.WIDTH(WIDTH)) u_first (
    .xIn   (aReg),
    .yIn   (subReg ? ~bReg : bReg),
    .cIn   (subReg),
    .sumOut(firstSum),
    .cOut  (firstCarry)
  );

  // Second adder: (A+B) + ~p + 1 on WIDTH+1 bits, or (A-B) + p.
  assign secondX = subReg ? {1'b0, firstSum} : {firstCarry, firstSum};
  assign secondY = subReg ? {1'b0, pReg}     : {1'b1, ~pReg};

  modadd_cpa #(.WIDTH(EXT)) u_second (
    .xIn   (secondX),
    .yIn   (secondY),
    .cIn   (~subReg),
    .sumOut(secondSum),
    .cOut  (secondCarry)
  );

  always_comb begin
    if (subReg) picked = firstCarry  ? firstSum : secondSum[WIDTH-1:0];
    else        picked = secondCarry ? secondSum[WIDTH-1:0] : firstSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  resReg <= '0;
    else if (strobes.computeEn) resReg <= picked;
  end

  assign result = resReg;
endmodule

// File: rtl/modadd_unit.sv
module modadd_unit
  import modadd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             opSub,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] modP,
  output logic [WIDTH-1:0] result,
  output logic             resultValid
);
  ctrlStrobes_t strobes;

  modadd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobes (strobes),
    .validOut(resultValid)
  );

  modadd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opSub  (opSub),
    .opA    (opA),
    .opB    (opB),
    .modP   (modP),
    .result (result)
  );
endmodule

// File: rtl/modadd_unit_chk.sv
module modadd_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [WIDTH-1:0] modP,
  input logic [WIDTH-1:0] result,
  input logic             resultValid
);
  logic             armed;
  logic [WIDTH-1:0] heldP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      heldP <= '0;
    end else begin
      armed <= startIn && !armed;
      if (startIn && !armed) heldP <= modP;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |-> !resultValid);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> resultValid);

  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r6_valid_needs_accept: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(armed));

  a_r3_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  a_r8_in_range: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (result < heldP));
endmodule

bind modadd_unit modadd_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startIn    (startIn),
  .modP       (modP),
  .result     (result),
  .resultValid(resultValid)
);

// File: tb/modadd_unit_tb.sv
module modadd_unit_tb;
  localparam int W  = 16;
  localparam int NV = 12;
  localparam int VW = 1 + 3 * W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic         opSub = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, modP = '0;
  logic [W-1:0] result;
  logic         resultValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  modadd_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opSub(opSub),
    .opA(opA), .opB(opB), .modP(modP),
    .result(result), .resultValid(resultValid)
  );

  // {sub, a, b, p}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 16'd0,      16'd0,      16'd97},
    {1'b0, 16'd40,     16'd57,     16'd97},
    {1'b0, 16'd0,      16'd96,     16'd97},
    {1'b0, 16'd50,     16'd60,     16'd97},
    {1'b0, 16'd96,     16'd96,     16'd97},
    {1'b0, 16'hFFF0,   16'hFFF0,   16'hFFF1},
    {1'b0, 16'd3,      16'd4,      16'd97},
    {1'b1, 16'd20,     16'd20,     16'd97},
    {1'b1, 16'd0,      16'd96,     16'd97},
    {1'b1, 16'd60,     16'd10,     16'd97},
    {1'b1, 16'd10,     16'd60,     16'd97},
    {1'b1, 16'd0,      16'hFFF0,   16'hFFF1}
  };

  function automatic logic [W-1:0] refModel(input logic s, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [W-1:0] p);
    longint r;
    if (s) r = longint'(a) - longint'(b);
    else   r = longint'(a) + longint'(b);
    r = r % longint'(p);
    if (r < 0) r = r + longint'(p);
    return W'(r);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start one operation; scramble pins after acceptance; check result and pulse.
  task automatic runOp(input string req, input logic s, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] p);
    logic [W-1:0] exp;
    exp = refModel(s, a, b, p);
    @(negedge clk);
    opSub = s; opA = a; opB = b; modP = p; startIn = 1'b1;
    @(negedge clk);                 // accepted at E0
    startIn = 1'b0;
    opSub = ~s; opA = ~a; opB = a; modP = 16'h0003;   // R7 disturbance
    check({req, " R2 valid low before E0+1"}, W'(resultValid), W'(0));
    @(negedge clk);                 // after E0+1
    check({req, " R2 valid pulse"}, W'(resultValid), W'(1));
    check(req, result, exp);
    check({req, " R8 below modulus"}, W'(result < p), W'(1));
    @(negedge clk);
    check({req, " R2 single-cycle valid"}, W'(resultValid), W'(0));
    check({req, " R3 result held"}, result, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    check("R1 valid during reset", W'(resultValid), W'(0));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, '0);
    check("R1 valid after reset", W'(resultValid), W'(0));

    // Vector table: R4 addition, R5 subtraction, R7 pins scrambled after accept
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      runOp(v[VW-1] ? "R5 R7 sub" : "R4 R7 add", v[VW-1], v[3*W-1:2*W], v[2*W-1:W], v[W-1:0]);
    end

    // R6: start held across the accept edge and the following edge
    @(negedge clk);
    opSub = 1'b0; opA = 16'd30; opB = 16'd80; modP = 16'd97; startIn = 1'b1;
    @(negedge clk);                 // accepted at E0
    opA = 16'd1; opB = 16'd1;       // still starting during compute cycle
    @(negedge clk);                 // after E0+1
    startIn = 1'b0;
    check("R6 first valid", W'(resultValid), W'(1));
    check("R6 first result", result, 16'd13);
    @(negedge clk);
    check("R6 ignored start no valid", W'(resultValid), W'(0));
    check("R6 result undisturbed", result, 16'd13);
    @(negedge clk);
    check("R6 still no valid", W'(resultValid), W'(0));

    // R3: idle cycles keep the result
    repeat (5) @(negedge clk);
    check("R3 result held while idle", result, 16'd13);

    // R1: reset mid-idle clears again
    rstN = 1'b0;
    #1;
    check("R1 async reset clears result", result, '0);
    @(negedge clk);
    rstN = 1'b1;
    runOp("R5 after reset sub", 1'b1, 16'd5, 16'd9, 16'd97);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule